// File: doc/BRIEF.md
# Stop-Clock Power State Controller

This block sequences the low-power states of a processor package built from several dies. It follows one of six one-hot states: Normal, Halt, Halt Snoop, Grant Pending, Stop Grant and Stop Grant Snoop. An active-low stop-clock request moves the package into Stop Grant. A halt indication that comes with a halt bus cycle parks it in Halt. A bus snoop takes a short detour from either low-power state and then returns to the state it left.

On a stop-clock request the block sends one single-cycle acknowledge request per die, in die order. It collects one response strobe per die. After the last strobe it waits a fixed settle time, bounded well inside twenty clocks, and then enters Stop Grant. While the dies are stopped, a bus-init event is held in a pending flag until it is cleared. A release of the stop-clock request that comes before the grant sets a sticky error flag. A reset event clears both flags but does not change the power state.

Top module: `stop_clock_ctrl`

## Requirements
- R1: While `rstPor` is high, and after it falls, `stateOut` shows Normal, `ackReq` is zero, and `binitPending` and `protoErr` are low.
- R2: `stateOut` is one-hot. The bit positions are: 0 Normal, 1 Halt, 2 Halt Snoop, 3 Grant Pending, 4 Stop Grant, 5 Stop Grant Snoop.
- R3: In Normal, with stop-clock inactive, `haltReq` moves the block to Halt at the next edge. In Halt, any bit of `wakeEvt` returns it to Normal.
- R4: A low `stopReqN` in Normal or Halt moves the block to Grant Pending. The cycle after entry raises `ackReq[0]`, the following cycle raises `ackReq[1]`, and each bit pulses exactly once.
- R5: Stop Grant is shown ENTRY_DELAY+1 clocks (default 5) after the edge at which the last die's `ackDone` strobe was captured. This never exceeds 20 clocks.
- R6: In Stop Grant, with no snoop present, a high `stopReqN` returns the block to Normal at the next edge. While `stopReqN` stays low, the block remains in Stop Grant.
- R7: A high `stopReqN` during Grant Pending sets `protoErr`. The flag stays set until a reset event, and the grant sequence still completes.
- R8: `snoopHit` in Stop Grant enters Stop Grant Snoop, and `snoopHit` in Halt enters Halt Snoop. `snoopDone` returns the block to the state it came from.
- R9: In a snoop state the block moves only on `snoopDone`. A stop-clock change or a wake event that arrives meanwhile takes effect only after the block has returned.
- R10: `wakeEvt[1]` (bus init) sets `binitPending` in Grant Pending, Stop Grant or Stop Grant Snoop, and does not change the state. In other states it leaves the flag clear. `binitClr` clears the flag.
- R11: `wakeEvt[5]` (reset event) clears `binitPending` and `protoErr` at the next edge, and the block remains in Stop Grant when it is there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstPor | input | 1 | Asynchronous power-on reset, active high |
| stopReqN | input | 1 | Stop-clock request, active low |
| haltReq | input | 1 | Halt or monitor-wait executed with a halt bus cycle issued |
| snoopHit | input | 1 | Bus snoop detected |
| snoopDone | input | 1 | Snoop service complete |
| wakeEvt | input | 7 | Wake events: 0 init, 1 bus init, 2 intr, 3 nmi, 4 smi, 5 reset, 6 bus interrupt |
| ackDone | input | NUM_DIE | Per-die response-phase strobe of the acknowledge cycle |
| binitClr | input | 1 | Clears the pending bus-init flag |
| ackReq | output | NUM_DIE | Per-die acknowledge bus-cycle request pulse |
| stateOut | output | 6 | One-hot current state |
| binitPending | output | 1 | Deferred bus-init event held |
| protoErr | output | 1 | Sticky early-release error |

## Verification
On every cycle, the assertions check that the state is one-hot and that acknowledge requests are single pulses on at most one die. They also check that a snoop state holds until its completion strobe, that Stop Grant is left only by release or by a snoop, and that the error flag is sticky. They further check that the grant window stays inside the bound and that a reset event keeps Stop Grant and clears the flags. Only the bench's scenarios can show the exact cycle on which each die's request appears and the exact settle count after the last response. The same holds for the ordering of deferred stop and wake events around a snoop, and for the contrast between bus-init in Normal and bus-init in Stop Grant.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int NST     = 6;
  localparam int WAKE_W  = 7;
  localparam int ST_NORM = 0;
  localparam int ST_HALT = 1;
  localparam int ST_HSNP = 2;
  localparam int ST_PEND = 3;
  localparam int ST_GRNT = 4;
  localparam int ST_GSNP = 5;
  localparam int WK_BINIT = 1;
  localparam int WK_RESET = 5;

  typedef struct packed {
    logic enterPend;
    logic inPend;
    logic holdBinit;
    logic earlyRelease;
  } scStrobes_t;
endpackage

// File: rtl/sc_ctrl.sv
module sc_ctrl
  import sc_pkg::*;
(
  input  logic           clk,
  input  logic           rstPor,
  input  logic           stopReqN,
  input  logic           haltReq,
  input  logic           snoopHit,
  input  logic           snoopDone,
  input  logic           wakeAny,
  input  logic           readyGrant,
  output logic [NST-1:0] stQ,
  output scStrobes_t     strobes
);
  logic [NST-1:0] stD;

  always_comb begin
    stD = '0;
    if (stQ[ST_NORM]) begin
      if (!stopReqN)    stD[ST_PEND] = 1'b1;
      else if (haltReq) stD[ST_HALT] = 1'b1;
      else              stD[ST_NORM] = 1'b1;
    end else if (stQ[ST_HALT]) begin
      if (snoopHit)      stD[ST_HSNP] = 1'b1;
      else if (!stopReqN) stD[ST_PEND] = 1'b1;
      else if (wakeAny)  stD[ST_NORM] = 1'b1;
      else               stD[ST_HALT] = 1'b1;
    end else if (stQ[ST_HSNP]) begin
      if (snoopDone) stD[ST_HALT] = 1'b1;
      else           stD[ST_HSNP] = 1'b1;
    end else if (stQ[ST_PEND]) begin
      if (readyGrant) stD[ST_GRNT] = 1'b1;
      else            stD[ST_PEND] = 1'b1;
    end else if (stQ[ST_GRNT]) begin
      if (snoopHit)      stD[ST_GSNP] = 1'b1;
      else if (stopReqN) stD[ST_NORM] = 1'b1;
      else               stD[ST_GRNT] = 1'b1;
    end else if (stQ[ST_GSNP]) begin
      if (snoopDone) stD[ST_GRNT] = 1'b1;
      else           stD[ST_GSNP] = 1'b1;
    end else begin
      stD[ST_NORM] = 1'b1;
    end
  end

  always_ff @(posedge clk or posedge rstPor) begin
    if (rstPor) stQ <= NST'(1) << ST_NORM;
    else        stQ <= stD;
  end

  always_comb begin
    strobes.enterPend    = stD[ST_PEND] && !stQ[ST_PEND];
    strobes.inPend       = stQ[ST_PEND];
    strobes.holdBinit    = stQ[ST_PEND] || stQ[ST_GRNT] || stQ[ST_GSNP];
    strobes.earlyRelease = stQ[ST_PEND] && stopReqN;
  end

  p_onehot_r2: assert property (@(posedge clk) disable iff (rstPor)
    $onehot(stQ));
  p_grant_exit_r6: assert property (@(posedge clk) disable iff (rstPor)
    stQ[ST_GRNT] && stopReqN && !snoopHit |=> stQ[ST_NORM]);
  p_snoop_return_r8: assert property (@(posedge clk) disable iff (rstPor)
    stQ[ST_GSNP] && snoopDone |=> stQ[ST_GRNT]);
  p_snoop_hold_r9: assert property (@(posedge clk) disable iff (rstPor)
    (stQ[ST_HSNP] || stQ[ST_GSNP]) && !snoopDone |=> $stable(stQ));
endmodule

// File: rtl/sc_dpath.sv
module sc_dpath
  import sc_pkg::*;
#(
  parameter int NUM_DIE     = 2,
  parameter int ENTRY_DELAY = 4,
  parameter int MAX_LAT     = 20
)(
  input  logic               clk,
  input  logic               rstPor,
  input  scStrobes_t         strobes,
  input  logic [NUM_DIE-1:0] ackDone,
  input  logic               binitEvt,
  input  logic               resetEvt,
  input  logic               binitClr,
  output logic [NUM_DIE-1:0] ackReq,
  output logic               readyGrant,
  output logic               binitPending,
  output logic               protoErr
);
  localparam int IDX_W = $clog2(NUM_DIE + 1);
  localparam int WIN_W = $clog2(MAX_LAT + 1);

  logic [IDX_W-1:0]   issueIdx;
  logic [NUM_DIE-1:0] doneMask;
  logic [WIN_W-1:0]   winCnt;
  logic               allDone;

  assign allDone = &doneMask;

  always_ff @(posedge clk or posedge rstPor) begin
    if (rstPor) begin
      issueIdx <= '0;
      doneMask <= '0;
      winCnt   <= '0;
    end else if (strobes.enterPend) begin
      issueIdx <= '0;
      doneMask <= '0;
      winCnt   <= '0;
    end else if (strobes.inPend) begin
      if (issueIdx != IDX_W'(NUM_DIE)) issueIdx <= issueIdx + 1'b1;
      doneMask <= doneMask | ackDone;
      if (allDone && winCnt != WIN_W'(ENTRY_DELAY)) winCnt <= winCnt + 1'b1;
    end
  end

  for (genvar d = 0; d < NUM_DIE; d++) begin : g_ack
    assign ackReq[d] = strobes.inPend && (issueIdx == IDX_W'(d));
  end

  assign readyGrant = strobes.inPend && allDone && (winCnt == WIN_W'(ENTRY_DELAY));

  always_ff @(posedge clk or posedge rstPor) begin
    if (rstPor) begin
      binitPending <= 1'b0;
      protoErr     <= 1'b0;
    end else if (resetEvt) begin
      binitPending <= 1'b0;
      protoErr     <= 1'b0;
    end else begin
      if (binitClr)                               binitPending <= 1'b0;
      else if (strobes.holdBinit && binitEvt)     binitPending <= 1'b1;
      if (strobes.earlyRelease)                   protoErr     <= 1'b1;
    end
  end

  p_ack_onehot_r4: assert property (@(posedge clk) disable iff (rstPor)
    $onehot0(ackReq));
  p_ack_pulse_r4: assert property (@(posedge clk) disable iff (rstPor)
    ackReq[0] |=> !ackReq[0]);
  p_grant_leaves_pend_r5: assert property (@(posedge clk) disable iff (rstPor)
    readyGrant |=> !strobes.inPend);
  p_window_bound_r5: assert property (@(posedge clk) disable iff (rstPor)
    strobes.inPend && allDone |-> winCnt < WIN_W'(MAX_LAT));
  p_err_sticky_r7: assert property (@(posedge clk) disable iff (rstPor)
    protoErr && !resetEvt |=> protoErr);
  p_binit_rise_r10: assert property (@(posedge clk) disable iff (rstPor)
    $rose(binitPending) |-> $past(strobes.holdBinit));
endmodule

// File: rtl/stop_clock_ctrl.sv
module stop_clock_ctrl
  import sc_pkg::*;
#(
  parameter int NUM_DIE     = 2,
  parameter int ENTRY_DELAY = 4,
  parameter int MAX_LAT     = 20
)(
  input  logic               clk,
  input  logic               rstPor,
  input  logic               stopReqN,
  input  logic               haltReq,
  input  logic               snoopHit,
  input  logic               snoopDone,
  input  logic [WAKE_W-1:0]  wakeEvt,
  input  logic [NUM_DIE-1:0] ackDone,
  input  logic               binitClr,
  output logic [NUM_DIE-1:0] ackReq,
  output logic [NST-1:0]     stateOut,
  output logic               binitPending,
  output logic               protoErr
);
  scStrobes_t strobes;
  logic       readyGrant;

  sc_ctrl u_ctrl (
    .clk        (clk),
    .rstPor     (rstPor),
    .stopReqN   (stopReqN),
    .haltReq    (haltReq),
    .snoopHit   (snoopHit),
    .snoopDone  (snoopDone),
    .wakeAny    (|wakeEvt),
    .readyGrant (readyGrant),
    .stQ        (stateOut),
    .strobes    (strobes)
  );

  sc_dpath #(
    .NUM_DIE     (NUM_DIE),
    .ENTRY_DELAY (ENTRY_DELAY),
    .MAX_LAT     (MAX_LAT)
  ) u_dpath (
    .clk          (clk),
    .rstPor       (rstPor),
    .strobes      (strobes),
    .ackDone      (ackDone),
    .binitEvt     (wakeEvt[WK_BINIT]),
    .resetEvt     (wakeEvt[WK_RESET]),
    .binitClr     (binitClr),
    .ackReq       (ackReq),
    .readyGrant   (readyGrant),
    .binitPending (binitPending),
    .protoErr     (protoErr)
  );

  p_reset_keeps_grant_r11: assert property (@(posedge clk) disable iff (rstPor)
    stateOut[ST_GRNT] && wakeEvt[WK_RESET] && !stopReqN && !snoopHit |=> stateOut[ST_GRNT]);
  p_reset_clears_r11: assert property (@(posedge clk) disable iff (rstPor)
    wakeEvt[WK_RESET] |=> !protoErr && !binitPending);
endmodule

// File: tb/stop_clock_ctrl_bench.sv
`timescale 1ns/1ps
module stop_clock_ctrl_bench;
  localparam logic [5:0] SN  = 6'b000001;
  localparam logic [5:0] SH  = 6'b000010;
  localparam logic [5:0] SHS = 6'b000100;
  localparam logic [5:0] SP  = 6'b001000;
  localparam logic [5:0] SG  = 6'b010000;
  localparam logic [5:0] SGS = 6'b100000;
  localparam logic [6:0] W0  = 7'b0000000;
  localparam logic [6:0] WBI = 7'b0000010;
  localparam logic [6:0] WIN = 7'b0000100;
  localparam logic [6:0] WRS = 7'b0100000;
  localparam logic [6:0] WBU = 7'b1000000;

  logic clk = 1'b0;
  logic rstPor = 1'b1;
  logic stopReqN = 1'b1, haltReq = 1'b0, snoopHit = 1'b0, snoopDone = 1'b0;
  logic [6:0] wakeEvt = '0;
  logic [1:0] ackDone = '0;
  logic binitClr = 1'b0;
  logic [1:0] ackReq;
  logic [5:0] stateOut;
  logic binitPending, protoErr;

  int total = 0, bad = 0, cyc = 0;
  bit finished = 0;

  typedef struct {
    int         due;
    logic [5:0] st;
    logic [1:0] ack;
    logic       bp;
    logic       pe;
    string      tag;
  } exp_t;
  exp_t expQ[$];

  stop_clock_ctrl u_stop_clock_ctrl (
    .clk(clk), .rstPor(rstPor), .stopReqN(stopReqN), .haltReq(haltReq),
    .snoopHit(snoopHit), .snoopDone(snoopDone), .wakeEvt(wakeEvt),
    .ackDone(ackDone), .binitClr(binitClr), .ackReq(ackReq),
    .stateOut(stateOut), .binitPending(binitPending), .protoErr(protoErr)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: pop every expectation that is due and compare.
  always @(negedge clk) begin
    while (expQ.size() > 0 && expQ[0].due <= cyc) begin
      exp_t e;
      e = expQ.pop_front();
      total++;
      if (stateOut !== e.st || ackReq !== e.ack || binitPending !== e.bp || protoErr !== e.pe) begin
        bad++;
        $display("FAIL %s: state=%b ack=%b bp=%b pe=%b expected state=%b ack=%b bp=%b pe=%b",
                 e.tag, stateOut, ackReq, binitPending, protoErr, e.st, e.ack, e.bp, e.pe);
      end
    end
  end

  // Driver: apply one cycle of stimulus and queue the outcome after the next edge.
  task automatic drv(input logic sN, input logic hl, input logic sh, input logic sd,
                     input logic [6:0] wk, input logic [1:0] ad, input logic bc,
                     input logic [5:0] es, input logic [1:0] ea, input logic ebp,
                     input logic epe, input string tag);
    @(posedge clk);
    #5;
    stopReqN = sN; haltReq = hl; snoopHit = sh; snoopDone = sd;
    wakeEvt = wk; ackDone = ad; binitClr = bc;
    expQ.push_back('{cyc + 1, es, ea, ebp, epe, tag});
  endtask

  task automatic window(input logic sN, input logic epe);
    for (int k = 0; k < 4; k++) drv(sN,0,0,0,W0,2'b00,0, SP,2'b00,0,epe,"R5 settle window");
    drv(sN,0,0,0,W0,2'b00,0, SG,2'b00,0,epe,"R5 grant reached on settle count");
  endtask

  initial begin
    #35;
    expQ.push_back('{cyc, SN, 2'b00, 1'b0, 1'b0, "R1 state during reset"});
    repeat (2) @(posedge clk);
    #5 rstPor = 1'b0;

    // Halt entry and wake-up
    drv(1,0,0,0,W0,2'b00,0, SN,2'b00,0,0,"R1 Normal after reset");
    drv(1,1,0,0,W0,2'b00,0, SH,2'b00,0,0,"R3 halt entry");
    drv(1,0,0,0,W0,2'b00,0, SH,2'b00,0,0,"R3 halt holds");
    drv(1,0,0,0,WIN,2'b00,0, SN,2'b00,0,0,"R3 intr wakes");
    drv(1,1,0,0,W0,2'b00,0, SH,2'b00,0,0,"R3 halt again");
    drv(1,0,0,0,WBU,2'b00,0, SN,2'b00,0,0,"R3 bus interrupt wakes");
    drv(1,0,0,0,WBI,2'b00,0, SN,2'b00,0,0,"R10 bus init in Normal not held");

    // Clean grant, responses on separate cycles
    drv(0,0,0,0,W0,2'b00,0, SP,2'b01,0,0,"R4 die 0 request");
    drv(0,0,0,0,W0,2'b00,0, SP,2'b10,0,0,"R4 die 1 request");
    drv(0,0,0,0,W0,2'b00,0, SP,2'b00,0,0,"R4 requests finished");
    drv(0,0,0,0,W0,2'b01,0, SP,2'b00,0,0,"R5 first response");
    drv(0,0,0,0,W0,2'b10,0, SP,2'b00,0,0,"R5 last response");
    window(0, 0);
    drv(0,0,0,0,W0,2'b00,0, SG,2'b00,0,0,"R6 grant holds");
    drv(1,0,0,0,W0,2'b00,0, SN,2'b00,0,0,"R6 release to Normal");

    // Early release
    drv(0,0,0,0,W0,2'b00,0, SP,2'b01,0,0,"R4 die 0 request");
    drv(1,0,0,0,W0,2'b00,0, SP,2'b10,0,1,"R7 early release flagged");
    drv(1,0,0,0,W0,2'b11,0, SP,2'b00,0,1,"R7 responses after error");
    window(1, 1);
    drv(1,0,0,0,W0,2'b00,0, SN,2'b00,0,1,"R7 flag sticky after exit");
    drv(1,0,0,0,WRS,2'b00,0, SN,2'b00,0,0,"R11 reset clears error");

    // Snoop detour and bus init in Stop Grant
    drv(0,0,0,0,W0,2'b00,0, SP,2'b01,0,0,"R4 die 0 request");
    drv(0,0,0,0,W0,2'b11,0, SP,2'b10,0,0,"R4 responses while issuing");
    window(0, 0);
    drv(0,0,0,0,WBI,2'b00,0, SG,2'b00,1,0,"R10 bus init held in grant");
    drv(0,0,1,0,W0,2'b00,0, SGS,2'b00,1,0,"R8 grant snoop detour");
    drv(1,0,0,0,W0,2'b00,0, SGS,2'b00,1,0,"R9 release deferred in snoop");
    drv(0,0,0,1,W0,2'b00,0, SG,2'b00,1,0,"R8 snoop return to grant");
    drv(0,0,0,0,WRS,2'b00,0, SG,2'b00,0,0,"R11 reset keeps grant");
    drv(0,0,0,0,WBI,2'b00,0, SG,2'b00,1,0,"R10 bus init held again");
    drv(0,0,0,0,W0,2'b00,1, SG,2'b00,0,0,"R10 clear pending");
    drv(1,0,0,0,W0,2'b00,0, SN,2'b00,0,0,"R6 release to Normal");

    // Halt snoop with deferred stop
    drv(1,1,0,0,W0,2'b00,0, SH,2'b00,0,0,"R3 halt entry");
    drv(1,0,1,0,W0,2'b00,0, SHS,2'b00,0,0,"R8 halt snoop detour");
    drv(1,0,0,0,WIN,2'b00,0, SHS,2'b00,0,0,"R9 wake ignored in snoop");
    drv(0,0,0,0,W0,2'b00,0, SHS,2'b00,0,0,"R9 stop deferred in snoop");
    drv(0,0,0,1,W0,2'b00,0, SH,2'b00,0,0,"R8 return to halt");
    drv(0,0,0,0,W0,2'b00,0, SP,2'b01,0,0,"R9 stop taken after snoop");
    drv(0,0,0,0,W0,2'b00,0, SP,2'b10,0,0,"R4 die 1 request");
    drv(0,0,0,0,W0,2'b11,0, SP,2'b00,0,0,"R5 both responses");
    window(0, 0);
    drv(1,0,0,0,W0,2'b00,0, SN,2'b00,0,0,"R6 release to Normal");

    repeat (3) @(posedge clk);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #4000000;
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule